// File: doc/BRIEF.md
# Mode Register Load Controller

This block keeps the working copy of a DDR2-class memory device's main mode register. It watches a load-mode command strobe together with a bank-select code and a mode word. A load is taken only when the bank-select code is all zeros. Any other bank code belongs to an extended register, and this block ignores it. A load is accepted only when every bank reports idle, no read or write burst is running, and the previous load's settling window has run out. An accepted load replaces the whole mode word in one step. No field can be updated on its own.

The stored word is decoded into the settings the rest of the controller uses: burst length, burst ordering, read latency, write recovery, test mode and power-down exit speed. The DLL-reset request bit reads back as set for exactly one cycle and then clears itself. After an accepted load, a lockout counter holds `ready` low for the mode-register delay, and during that time other commands, such as a row activation, are not granted. A rejected load raises a one-cycle error pulse. An accepted load that carries a reserved field code is stored anyway, but it sets a sticky flag.

Top module: `modereg_ctrl`

## Requirements
- R1: After reset, `mode_q`, `load_err`, `rsv_flag` and `dll_reset` are 0, every decoded field output is 0, and `ready` is 1.
- R2: A load with `load_bank` = 0, `banks_idle` = 1, `burst_active` = 0 and `ready` = 1 is accepted. From the next cycle, `mode_q` holds all bits of `load_bits` together.
- R3: `mode_q[8]` and `dll_reset` equal `load_bits[8]` for exactly the one cycle after an accepted load, and are 0 afterwards. Every other bit of `mode_q` keeps its value until the next accepted load or reset.
- R4: A load with a nonzero `load_bank` has no effect. `mode_q`, `rsv_flag` and `ready` are unchanged and `load_err` stays 0.
- R5: A load with `load_bank` = 0 is rejected when `banks_idle` is 0, `burst_active` is 1 or `ready` is 0. A rejected load leaves `mode_q` and `rsv_flag` unchanged and drives `load_err` high for exactly the next cycle.
- R6: After an accepted load, `ready` is 0 for TMRD-1 cycles and then returns to 1. With the default TMRD = 2, the next command may be issued in the second cycle after the load.
- R7: Mode bits 6..4 give `cas_lat`. Codes 3..7 read back as latencies 3..7. Codes 0..2 are reserved and read back as 0.
- R8: Mode bits 11..9 give `wr_rec`. Code c in 1..7 reads back as c+1. Code 0 is reserved and reads back as 0.
- R9: Mode bits 2..0 give `burst_len`: code 2 gives 4, code 3 gives 8, and every other code is reserved and gives 0. Mode bit 3 drives `interleave` (1 = interleaved, 0 = sequential).
- R10: Mode bit 7 drives `test_mode`, and mode bit 12 drives `slow_exit` (1 = slow, low-power exit; 0 = fast exit).
- R11: `rsv_flag` is set by an accepted load that holds any reserved code in bits 2..0, 6..4 or 11..9. It is cleared by an accepted load that holds none, and no other event changes it.
- R12: `cmd_grant` is `cmd_req` AND `ready` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_req | input | 1 | Load-mode command strobe |
| load_bank | input | BANK_W | Bank-select code sent with the load |
| load_bits | input | MODE_W | Mode word sent with the load |
| banks_idle | input | 1 | All banks precharged |
| burst_active | input | 1 | A read or write burst is in progress |
| cmd_req | input | 1 | Request to issue any other command |
| cmd_grant | output | 1 | Other command may issue this cycle |
| ready | output | 1 | No mode-register lockout active |
| load_err | output | 1 | One-cycle pulse for a rejected load |
| rsv_flag | output | 1 | Sticky: last accepted load held a reserved code |
| mode_q | output | MODE_W | Stored mode word (bit 8 self-clearing) |
| dll_reset | output | 1 | One-cycle DLL reset request |
| cas_lat | output | 3 | Decoded read latency, 0 if reserved |
| wr_rec | output | 4 | Decoded write recovery, 0 if reserved |
| burst_len | output | 4 | Decoded burst length, 0 if reserved |
| interleave | output | 1 | Interleaved burst ordering |
| test_mode | output | 1 | Test mode selected |
| slow_exit | output | 1 | Slow power-down exit selected |

## Verification
The case of interest is a second load that lands inside the settling window of the previous one. In that cycle the lockout is expiring while the legality check is still being judged. The bench issues a load and, with default TMRD, follows it immediately with another valid load (optionally with a busy burst at the same time). The bench then expects exactly one error pulse, an unchanged word and flag, and `ready` back high in the following cycle. A further load then confirms that the window is really over.

// File: rtl/modereg_pkg.sv
package modereg_pkg;

    // Field positions inside the mode word; neighbouring logic decodes these.
    localparam int BL_LSB  = 0;
    localparam int BT_BIT  = 3;
    localparam int CL_LSB  = 4;
    localparam int TM_BIT  = 7;
    localparam int DLL_BIT = 8;
    localparam int WR_LSB  = 9;
    localparam int PD_BIT  = 12;
    localparam int FIELD_W = 3;
    localparam int USED_W  = PD_BIT + 1;

    // Decoded form of one mode word
    typedef struct packed {
        logic [2:0] cas;
        logic [3:0] wr;
        logic [3:0] blen;
        logic       il;
        logic       tm;
        logic       slow;
        logic       dll;
        logic       rsv;
    } mr_fields_t;

endpackage

// File: rtl/modereg_decode.sv
module modereg_decode
    import modereg_pkg::*;
(
    input  logic [USED_W-1:0] word,
    output mr_fields_t        fields
);

    logic [FIELD_W-1:0] cl_code;
    logic [FIELD_W-1:0] wr_code;
    logic [FIELD_W-1:0] bl_code;
    logic               cl_bad;
    logic               wr_bad;
    logic               bl_bad;

    always_comb begin
        cl_code = word[CL_LSB +: FIELD_W];
        wr_code = word[WR_LSB +: FIELD_W];
        bl_code = word[BL_LSB +: FIELD_W];

        cl_bad = (cl_code < 3'd3);
        wr_bad = (wr_code == 3'd0);
        bl_bad = (bl_code != 3'd2) && (bl_code != 3'd3);

        fields.cas  = cl_bad ? 3'd0 : cl_code;
        fields.wr   = wr_bad ? 4'd0 : ({1'b0, wr_code} + 4'd1);
        case (bl_code)
            3'd2:    fields.blen = 4'd4;
            3'd3:    fields.blen = 4'd8;
            default: fields.blen = 4'd0;
        endcase
        fields.il   = word[BT_BIT];
        fields.tm   = word[TM_BIT];
        fields.slow = word[PD_BIT];
        fields.dll  = word[DLL_BIT];
        fields.rsv  = cl_bad | wr_bad | bl_bad;
    end

    always_comb begin
        AST_DEC_CAS_LEGAL: assert (fields.cas == 3'd0 || fields.cas >= 3'd3); // R7
    end

endmodule

// File: rtl/modereg_lockout.sv
module modereg_lockout #(
    parameter int TMRD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready
);

    localparam int CW = (TMRD > 1) ? $clog2(TMRD) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(TMRD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } lock_t;

    lock_t lk_d;
    lock_t lk_q;

    always_comb begin
        lk_d = lk_q;
        if (start) begin
            lk_d.cnt = RELOAD;
        end else if (lk_q.cnt != '0) begin
            lk_d.cnt = lk_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign ready = (lk_q.cnt == '0);

    AST_LOCK_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ready); // R6

    generate
        if (TMRD > 1) begin : g_window
            AST_LOCK_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
                start |=> !ready); // R6
        end
    endgenerate

endmodule

// File: rtl/modereg_ctrl.sv
module modereg_ctrl
    import modereg_pkg::*;
#(
    parameter int MODE_W = 15,
    parameter int BANK_W = 3,
    parameter int TMRD   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    input  logic [BANK_W-1:0] load_bank,
    input  logic [MODE_W-1:0] load_bits,
    input  logic              banks_idle,
    input  logic              burst_active,
    input  logic              cmd_req,
    output logic              cmd_grant,
    output logic              ready,
    output logic              load_err,
    output logic              rsv_flag,
    output logic [MODE_W-1:0] mode_q,
    output logic              dll_reset,
    output logic [2:0]        cas_lat,
    output logic [3:0]        wr_rec,
    output logic [3:0]        burst_len,
    output logic              interleave,
    output logic              test_mode,
    output logic              slow_exit
);

    localparam logic [MODE_W-1:0] DLL_MASK = MODE_W'(1) << DLL_BIT;

    typedef struct packed {
        logic [MODE_W-1:0] word;
        mr_fields_t        fld;
        logic              err;
    } ctrl_t;

    ctrl_t      st_d;
    ctrl_t      st_q;
    mr_fields_t in_fld;
    logic       lock_ready;
    logic       hit;
    logic       legal;
    logic       accept;
    logic       reject;

    modereg_decode u_decode (
        .word   (load_bits[USED_W-1:0]),
        .fields (in_fld)
    );

    modereg_lockout #(.TMRD(TMRD)) u_lockout (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .ready (lock_ready)
    );

    always_comb begin
        hit    = load_req && (load_bank == '0);
        legal  = banks_idle && !burst_active && lock_ready;
        accept = hit && legal;
        reject = hit && !legal;

        st_d         = st_q;
        st_d.err     = reject;
        st_d.fld.dll = 1'b0;
        if (accept) begin
            st_d.word = load_bits & ~DLL_MASK;
            st_d.fld  = in_fld;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready      = lock_ready;
    assign cmd_grant  = cmd_req && lock_ready;
    assign load_err   = st_q.err;
    assign rsv_flag   = st_q.fld.rsv;
    assign dll_reset  = st_q.fld.dll;
    assign mode_q     = st_q.word | (st_q.fld.dll ? DLL_MASK : '0);
    assign cas_lat    = st_q.fld.cas;
    assign wr_rec     = st_q.fld.wr;
    assign burst_len  = st_q.fld.blen;
    assign interleave = st_q.fld.il;
    assign test_mode  = st_q.fld.tm;
    assign slow_exit  = st_q.fld.slow;

    AST_BANK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && load_bank != '0) |=> !load_err); // R4

    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |-> (st_q.word == $past(st_q.word))); // R5

    AST_BUSY_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && load_bank == '0 && (!banks_idle || burst_active)) |=> load_err); // R5

    AST_DLL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dll_reset |=> (!dll_reset || $past(accept))); // R3

    AST_RSV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> (rsv_flag == $past(rsv_flag))); // R11

    AST_LOCKED_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && TMRD > 1) |=> !cmd_grant); // R12

endmodule

// File: tb/modereg_ctrl_bench.sv
module modereg_ctrl_bench;

    localparam int TB_TMRD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_req = 1'b0;
    logic [2:0]  load_bank = '0;
    logic [14:0] load_bits = '0;
    logic        banks_idle = 1'b1;
    logic        burst_active = 1'b0;
    logic        cmd_req = 1'b0;
    logic        cmd_grant, ready, load_err, rsv_flag, dll_reset;
    logic [14:0] mode_q;
    logic [2:0]  cas_lat;
    logic [3:0]  wr_rec, burst_len;
    logic        interleave, test_mode, slow_exit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    modereg_ctrl #(.MODE_W(15), .BANK_W(3), .TMRD(TB_TMRD)) u_modereg_ctrl (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .load_bank(load_bank),
        .load_bits(load_bits), .banks_idle(banks_idle), .burst_active(burst_active),
        .cmd_req(cmd_req), .cmd_grant(cmd_grant), .ready(ready), .load_err(load_err),
        .rsv_flag(rsv_flag), .mode_q(mode_q), .dll_reset(dll_reset), .cas_lat(cas_lat),
        .wr_rec(wr_rec), .burst_len(burst_len), .interleave(interleave),
        .test_mode(test_mode), .slow_exit(slow_exit)
    );

    typedef struct {
        logic [14:0] mode;
        logic        rdy, err, rsv, dll, il, tm, slow;
        logic [2:0]  cas;
        logic [3:0]  wr, bl;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // Bench model state, written from the requirements
    logic [14:0] m_word = '0;
    logic        m_dll = 1'b0, m_err = 1'b0, m_rsv = 1'b0;
    int          m_cnt = 0;

    function automatic logic [14:0] mk(input int bl, input int bt, input int cl, input int tm,
                                       input int dll, input int wr, input int pd);
        logic [14:0] w;
        w = '0;
        w[2:0]   = 3'(bl);
        w[3]     = 1'(bt);
        w[6:4]   = 3'(cl);
        w[7]     = 1'(tm);
        w[8]     = 1'(dll);
        w[11:9]  = 3'(wr);
        w[12]    = 1'(pd);
        return w;
    endfunction

    function automatic logic is_rsv(input logic [14:0] w);
        return (w[6:4] < 3'd3) || (w[11:9] == 3'd0) || (w[2:0] != 3'd2 && w[2:0] != 3'd3);
    endfunction

    function automatic exp_t model_out(input string tag);
        exp_t e;
        e.mode = m_word | (m_dll ? 15'h0100 : 15'h0);
        e.rdy  = (m_cnt == 0);
        e.err  = m_err;
        e.rsv  = m_rsv;
        e.dll  = m_dll;
        e.cas  = (m_word[6:4] >= 3'd3) ? m_word[6:4] : 3'd0;
        e.wr   = (m_word[11:9] != 3'd0) ? ({1'b0, m_word[11:9]} + 4'd1) : 4'd0;
        e.bl   = (m_word[2:0] == 3'd2) ? 4'd4 : (m_word[2:0] == 3'd3) ? 4'd8 : 4'd0;
        e.il   = m_word[3];
        e.tm   = m_word[7];
        e.slow = m_word[12];
        e.tag  = tag;
        return e;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, expv);
        end
    endtask

    // Driver: one command per cycle; pushes the expected post-edge outputs
    task automatic step(input logic ld, input logic [2:0] bk, input logic [14:0] w,
                        input logic idle, input logic busy, input logic oth, input string tag);
        logic hit, legal, acc;
        @(negedge clk);
        load_req = ld; load_bank = bk; load_bits = w;
        banks_idle = idle; burst_active = busy; cmd_req = oth;
        #1;
        check_bit("R12 cmd_grant", cmd_grant, oth && (m_cnt == 0));
        hit   = ld && (bk == 3'd0);
        legal = idle && !busy && (m_cnt == 0);
        acc   = hit && legal;
        m_err = hit && !legal;
        m_dll = acc ? w[8] : 1'b0;
        if (acc) begin
            m_word = w & ~15'h0100;
            m_rsv  = is_rsv(w);
            m_cnt  = TB_TMRD - 1;
        end else if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
        end
        exp_q.push_back(model_out(tag));
    endtask

    task automatic idle_step(input string tag);
        step(1'b0, 3'd0, 15'h0, 1'b1, 1'b0, 1'b0, tag);
    endtask

    task automatic good_load(input logic [14:0] w, input string tag);
        step(1'b1, 3'd0, w, 1'b1, 1'b0, 1'b0, tag);
        for (int i = 1; i < TB_TMRD; i++) idle_step(tag);
    endtask

    // Monitor: compares each expectation a quarter period after the edge
    always @(posedge clk) begin
        exp_t e;
        #5;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            checks++;
            if (mode_q !== e.mode || ready !== e.rdy || load_err !== e.err ||
                rsv_flag !== e.rsv || dll_reset !== e.dll || cas_lat !== e.cas ||
                wr_rec !== e.wr || burst_len !== e.bl || interleave !== e.il ||
                test_mode !== e.tm || slow_exit !== e.slow) begin
                fails++;
                $display("FAIL %s: actual mode=%h rdy=%b err=%b rsv=%b dll=%b cl=%0d wr=%0d bl=%0d il=%b tm=%b sx=%b expected mode=%h rdy=%b err=%b rsv=%b dll=%b cl=%0d wr=%0d bl=%0d il=%b tm=%b sx=%b",
                         e.tag, mode_q, ready, load_err, rsv_flag, dll_reset, cas_lat, wr_rec,
                         burst_len, interleave, test_mode, slow_exit, e.mode, e.rdy, e.err,
                         e.rsv, e.dll, e.cas, e.wr, e.bl, e.il, e.tm, e.slow);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check_bit("R1 ready", ready, 1'b1);
        check_bit("R1 load_err", load_err, 1'b0);
        check_bit("R1 rsv_flag", rsv_flag, 1'b0);
        check_bit("R1 dll_reset", dll_reset, 1'b0);
        check_bit("R1 mode_q zero", mode_q == 15'h0, 1'b1);
        check_bit("R1 fields zero", (cas_lat == 0 && wr_rec == 0 && burst_len == 0), 1'b1);

        // R2/R3/R6: legal load with DLL reset, command blocked in the window
        step(1'b1, 3'd0, mk(3, 0, 5, 0, 1, 3, 0) | 15'h6000, 1'b1, 1'b0, 1'b0, "R2 R3 load all bits");
        step(1'b0, 3'd0, 15'h0, 1'b1, 1'b0, 1'b1, "R6 R12 lockout blocks command");
        step(1'b0, 3'd0, 15'h0, 1'b1, 1'b0, 1'b1, "R3 R6 dll cleared, ready back");

        // R4: extended bank codes ignored
        for (int b = 1; b < 8; b++)
            step(1'b1, 3'(b), mk(2, 1, 7, 1, 1, 7, 1), 1'b1, 1'b0, 1'b0, "R4 nonzero bank ignored");

        // R5: busy or not-idle loads rejected
        step(1'b1, 3'd0, mk(2, 1, 3, 0, 0, 1, 0), 1'b1, 1'b1, 1'b0, "R5 burst active rejected");
        step(1'b1, 3'd0, mk(2, 1, 3, 0, 0, 1, 0), 1'b0, 1'b0, 1'b0, "R5 bank busy rejected");
        idle_step("R5 error pulse ends");

        // R5/R6: second load inside the window, with and without busy
        step(1'b1, 3'd0, mk(2, 0, 4, 0, 0, 2, 0), 1'b1, 1'b0, 1'b0, "R2 load");
        step(1'b1, 3'd0, mk(3, 1, 6, 0, 0, 5, 1), 1'b1, 1'b0, 1'b0, "R5 R6 load in window rejected");
        step(1'b1, 3'd0, mk(3, 1, 6, 0, 0, 5, 1), 1'b1, 1'b0, 1'b1, "R6 window over, load taken");
        step(1'b1, 3'd0, mk(2, 0, 3, 0, 0, 1, 0), 1'b1, 1'b1, 1'b0, "R5 R6 busy plus window");
        idle_step("R6 ready after window");

        // R11: reserved code sets flag; rejected load keeps it; valid load clears it
        good_load(mk(3, 0, 1, 0, 0, 2, 0), "R11 reserved cas sets flag");
        step(1'b1, 3'd0, mk(3, 0, 5, 0, 0, 2, 0), 1'b0, 1'b0, 1'b0, "R11 rejected load keeps flag");
        step(1'b1, 3'd4, mk(3, 0, 5, 0, 0, 2, 0), 1'b1, 1'b0, 1'b0, "R11 other bank keeps flag");
        good_load(mk(3, 0, 5, 0, 0, 2, 0), "R11 valid load clears flag");

        // R10: test mode and slow exit
        good_load(mk(2, 1, 7, 1, 0, 7, 1), "R10 test mode and slow exit");
        good_load(mk(2, 1, 7, 0, 0, 7, 0), "R10 normal mode fast exit");

        // R7/R8/R9: every code of every field
        for (int c = 0; c < 8; c++) good_load(mk(3, 0, c, 0, 0, 3, 0), "R7 cas code");
        for (int c = 0; c < 8; c++) good_load(mk(2, 0, 4, 0, 0, c, 0), "R8 write recovery code");
        for (int c = 0; c < 8; c++) good_load(mk(c, c % 2, 4, 0, 0, 3, 0), "R9 burst length and type");

        repeat (3) idle_step("R3 stable idle");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule